// File: doc/BRIEF.md
# Command-Table Bus Controller Sequencer

This block steers the fetch, execute and report cycle of a dual-bus command/response bus controller. It rests in a halted state until the subsystem gives a low-to-high edge on the halt-request line. It then reads four words from an external instruction store: the instruction, the receive command, the transmit command and the data pointer. It decodes the instruction and passes the transfer to an external message engine through a one-cycle start pulse and a done pulse. The done pulse returns the transfer's error and status flags.

The instruction word carries its own retry count, retry conditions and interrupt conditions. When a transfer fails on a selected retry condition, the sequencer restarts the engine until the count is used up. It then asks for one report write. After that it either raises a three-cycle interrupt and halts, or pulses the increment line of the external instruction address counter. The level of halt-request at the end of each instruction chooses the mode. Low gives single-shot execution. High gives table-driven execution, which goes straight on to the next table entry.

Top module: `bcs_sequencer`

## Requirements
- R1: After reset `halted_o` is 1 and `start_o`, `irq_o`, `inc_o` and `rpt_wr_o` are 0. Leaving the halted state needs a low-to-high transition of `halt_req_i`. A level held high does not restart a halted sequencer.
- R2: A fetch reads code addresses 0, 1, 2, 3 in that order, one word per cycle with `store_rd_o` high. The words at addresses 1, 2 and 3 then appear on `rx_cmd_o`, `tx_cmd_o` and `dptr_o`.
- R3: The first instruction fetched after reset runs as a no-operation whatever its function field holds, so no start pulse is issued.
- R4: Function field bits [4:3] select the action: 00 execute, 01 self test, 10 monitor, 11 no-operation. Codes 00, 01 and 10 issue one `start_o` pulse per attempt, with `func_o` equal to the field and `msg_o` equal to bits [2:0]. Code 11 issues no start pulse and goes directly to the report.
- R5: `bus_sel_o` is {0, bit 5}. Bit 6 of the instruction has no effect on it.
- R6: A retry is triggered in any of these cases: bit 11 is set and the engine flags no response, an encoding error or a word-count error; bit 12 is set and it flags a status bit; bit 13 is set and it flags busy.
- R7: The retry count in bits [15:14] limits extra attempts, so a run has at most count+1 start pulses. `rpt_retry_o` is 1 during the report write exactly when at least one retry took place.
- R8: After the last attempt an interrupt is raised in any of these cases: bit 9 is set (always); bit 7 is set and no response is flagged; bit 8 is set and a status bit is flagged; bit 10 is set and an encoding or word-count error is flagged.
- R9: Every instruction produces exactly one one-cycle `rpt_wr_o`, and it comes before any interrupt.
- R10: An interrupt is a pulse on `irq_o` lasting `IRQ_CYCLES` (3) clocks. The sequencer then halts and gives no `inc_o`.
- R11: Without an interrupt, `inc_o` pulses for one cycle. The synchronised `halt_req_i` level is then sampled: low halts, high fetches the next instruction.
- R12: When `cmd_err_i` is high after a fetch of an executable instruction, no start pulse is issued, the report is written and an interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Asynchronous halt request; rising edge starts, level picks the mode |
| halted_o | output | 1 | High while halted |
| store_rd_o | output | 1 | Instruction store read strobe |
| store_addr_o | output | 2 | Instruction store code address |
| store_data_i | input | 16 | Instruction store word, combinational from the address |
| cmd_err_i | input | 1 | Command validation error, sampled the cycle after fetch |
| start_o | output | 1 | One-cycle start pulse to the message engine |
| func_o | output | 2 | Decoded function code |
| msg_o | output | 3 | Decoded message code |
| bus_sel_o | output | 2 | Bus select, upper bit always 0 |
| rx_cmd_o | output | 16 | Fetched receive command word |
| tx_cmd_o | output | 16 | Fetched transmit command word |
| dptr_o | output | 16 | Fetched data pointer word |
| done_i | input | 1 | One-cycle completion pulse from the engine |
| no_resp_i | input | 1 | Engine flag: no response, valid with done_i |
| enc_err_i | input | 1 | Engine flag: encoding error |
| wc_err_i | input | 1 | Engine flag: word count error |
| stat_set_i | input | 1 | Engine flag: status bit set or wrong responder |
| busy_i | input | 1 | Engine flag: responder busy |
| rpt_wr_o | output | 1 | One-cycle report write request |
| rpt_retry_o | output | 1 | Retry-used flag for the report |
| irq_o | output | 1 | Interrupt pulse |
| inc_o | output | 1 | Increment pulse for the external instruction address counter |

## Verification
The hardest case to reach is the retry limit meeting every combination of retry flags and failure kinds. Each limited attempt must end in a report with the retry-used flag. The bench drives a scripted engine that returns the same failure on every attempt. It sweeps all retry counts, all eight retry-flag masks and four failure kinds, and checks the start-pulse count and the retry flag against the arithmetic expectation. A second sweep crosses all sixteen interrupt masks with five failure kinds. A held-high request after an interrupt checks that only a new edge releases the halt.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned CODE_W = 2;
    localparam int unsigned RCNT_W = 2;

    // instruction field positions
    localparam int unsigned B_RCNT_LO  = 14;
    localparam int unsigned B_R_ERR    = 11;
    localparam int unsigned B_R_STAT   = 12;
    localparam int unsigned B_R_BUSY   = 13;
    localparam int unsigned B_I_NORESP = 7;
    localparam int unsigned B_I_STAT   = 8;
    localparam int unsigned B_I_ALWAYS = 9;
    localparam int unsigned B_I_WORD   = 10;
    localparam int unsigned B_BUS      = 5;
    localparam int unsigned B_FUNC_LO  = 3;

    localparam logic [1:0] FN_EXEC = 2'b00;
    localparam logic [1:0] FN_TEST = 2'b01;
    localparam logic [1:0] FN_MON  = 2'b10;
    localparam logic [1:0] FN_NOOP = 2'b11;

    typedef enum logic [2:0] {
        ST_HALT, ST_FETCH, ST_CHECK, ST_START, ST_WAIT, ST_REPORT, ST_IRQ, ST_INC
    } state_e;

    typedef struct packed {
        logic [RCNT_W-1:0] retry_cnt;
        logic              r_busy;
        logic              r_stat;
        logic              r_err;
        logic              i_word;
        logic              i_always;
        logic              i_stat;
        logic              i_noresp;
        logic              bus;
        logic [1:0]        func;
        logic [2:0]        msg;
    } instr_t;

    typedef struct packed {
        logic no_resp;
        logic enc_err;
        logic wc_err;
        logic stat_set;
        logic busy;
    } xfer_flags_t;
endpackage

// File: rtl/bcs_sync_edge.sv
module bcs_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/bcs_instr_decode.sv
module bcs_instr_decode
    import bcs_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              force_noop_i,
    output instr_t            dec_o
);
    logic unused_bit6;
    assign unused_bit6 = word_i[6];

    always_comb begin
        dec_o.retry_cnt = word_i[B_RCNT_LO +: RCNT_W];
        dec_o.r_err     = word_i[B_R_ERR];
        dec_o.r_stat    = word_i[B_R_STAT];
        dec_o.r_busy    = word_i[B_R_BUSY];
        dec_o.i_noresp  = word_i[B_I_NORESP];
        dec_o.i_stat    = word_i[B_I_STAT];
        dec_o.i_always  = word_i[B_I_ALWAYS];
        dec_o.i_word    = word_i[B_I_WORD];
        dec_o.bus       = word_i[B_BUS];
        dec_o.func      = force_noop_i ? FN_NOOP : word_i[B_FUNC_LO +: 2];
        dec_o.msg       = word_i[2:0];
    end
endmodule

// File: rtl/bcs_outcome.sv
module bcs_outcome
    import bcs_pkg::*;
(
    input  instr_t      dec_i,
    input  xfer_flags_t flags_i,
    output logic        retry_hit_o,
    output logic        irq_hit_o
);
    logic word_bad;

    always_comb begin
        word_bad    = flags_i.enc_err | flags_i.wc_err;
        retry_hit_o = (dec_i.r_err  & (flags_i.no_resp | word_bad))
                    | (dec_i.r_stat & flags_i.stat_set)
                    | (dec_i.r_busy & flags_i.busy);
        irq_hit_o   = dec_i.i_always
                    | (dec_i.i_noresp & flags_i.no_resp)
                    | (dec_i.i_stat   & flags_i.stat_set)
                    | (dec_i.i_word   & word_bad);
    end
endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
    import bcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IRQ_CYCLES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req_i,
    output logic              halted_o,
    output logic              store_rd_o,
    output logic [CODE_W-1:0] store_addr_o,
    input  logic [WORD_W-1:0] store_data_i,
    input  logic              cmd_err_i,
    output logic              start_o,
    output logic [1:0]        func_o,
    output logic [2:0]        msg_o,
    output logic [1:0]        bus_sel_o,
    output logic [WORD_W-1:0] rx_cmd_o,
    output logic [WORD_W-1:0] tx_cmd_o,
    output logic [WORD_W-1:0] dptr_o,
    input  logic              done_i,
    input  logic              no_resp_i,
    input  logic              enc_err_i,
    input  logic              wc_err_i,
    input  logic              stat_set_i,
    input  logic              busy_i,
    output logic              rpt_wr_o,
    output logic              rpt_retry_o,
    output logic              irq_o,
    output logic              inc_o
);
    localparam int unsigned TMR_W    = $clog2(IRQ_CYCLES + 1);
    localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

    typedef struct packed {
        state_e             state;
        logic [CODE_W-1:0]  idx;
        logic [WORD_W-1:0]  instr;
        logic [WORD_W-1:0]  rx;
        logic [WORD_W-1:0]  tx;
        logic [WORD_W-1:0]  dp;
        logic               first;
        logic [RCNT_W-1:0]  retries;
        logic               retried;
        logic               irq_pend;
        logic [TMR_W-1:0]   tmr;
    } regs_t;

    regs_t r_q, r_d;

    logic        req_level, req_rise;
    instr_t      dec;
    xfer_flags_t flags;
    logic        retry_hit, irq_hit;

    bcs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (halt_req_i),
        .level_o (req_level),
        .rise_o  (req_rise)
    );

    bcs_instr_decode u_dec (
        .word_i       (r_q.instr),
        .force_noop_i (r_q.first),
        .dec_o        (dec)
    );

    assign flags = '{no_resp: no_resp_i, enc_err: enc_err_i, wc_err: wc_err_i,
                     stat_set: stat_set_i, busy: busy_i};

    bcs_outcome u_out (
        .dec_i       (dec),
        .flags_i     (flags),
        .retry_hit_o (retry_hit),
        .irq_hit_o   (irq_hit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_HALT: begin
                if (req_rise) begin
                    r_d.state = ST_FETCH;
                    r_d.idx   = '0;
                end
            end
            ST_FETCH: begin
                unique case (r_q.idx)
                    2'd0:    r_d.instr = store_data_i;
                    2'd1:    r_d.rx    = store_data_i;
                    2'd2:    r_d.tx    = store_data_i;
                    default: r_d.dp    = store_data_i;
                endcase
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == LAST_CODE) r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                r_d.first   = 1'b0;
                r_d.retries = dec.retry_cnt;
                r_d.retried = 1'b0;
                if (dec.func == FN_NOOP) begin
                    r_d.irq_pend = dec.i_always;
                    r_d.state    = ST_REPORT;
                end else if (cmd_err_i) begin
                    r_d.irq_pend = 1'b1;
                    r_d.state    = ST_REPORT;
                end else begin
                    r_d.state = ST_START;
                end
            end
            ST_START: r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (done_i) begin
                    if (retry_hit && (r_q.retries != '0)) begin
                        r_d.retries = r_q.retries - 1'b1;
                        r_d.retried = 1'b1;
                        r_d.state   = ST_START;
                    end else begin
                        r_d.irq_pend = irq_hit;
                        r_d.state    = ST_REPORT;
                    end
                end
            end
            ST_REPORT: begin
                if (r_q.irq_pend) begin
                    r_d.tmr   = TMR_W'(IRQ_CYCLES - 1);
                    r_d.state = ST_IRQ;
                end else begin
                    r_d.state = ST_INC;
                end
            end
            ST_IRQ: begin
                if (r_q.tmr == '0) r_d.state = ST_HALT;
                else               r_d.tmr   = r_q.tmr - 1'b1;
            end
            default: begin
                r_d.idx   = '0;
                r_d.state = req_level ? ST_FETCH : ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_HALT;
            r_q.first <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted_o     = (r_q.state == ST_HALT);
    assign store_rd_o   = (r_q.state == ST_FETCH);
    assign store_addr_o = r_q.idx;
    assign start_o      = (r_q.state == ST_START);
    assign func_o       = dec.func;
    assign msg_o        = dec.msg;
    assign bus_sel_o    = {1'b0, dec.bus};
    assign rx_cmd_o     = r_q.rx;
    assign tx_cmd_o     = r_q.tx;
    assign dptr_o       = r_q.dp;
    assign rpt_wr_o     = (r_q.state == ST_REPORT);
    assign rpt_retry_o  = r_q.retried;
    assign irq_o        = (r_q.state == ST_IRQ);
    assign inc_o        = (r_q.state == ST_INC);
endmodule

// File: rtl/bcs_sequencer_chk.sv
module bcs_sequencer_chk #(
    parameter int unsigned IRQ_CYCLES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       halted_o,
    input logic       store_rd_o,
    input logic [1:0] store_addr_o,
    input logic       start_o,
    input logic       rpt_wr_o,
    input logic       irq_o,
    input logic       inc_o
);
    logic [7:0] irq_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     irq_len_q <= '0;
        else if (irq_o) irq_len_q <= irq_len_q + 1'b1;
        else            irq_len_q <= '0;
    end

    p_fetch_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rd_o && $past(store_rd_o)) |-> (store_addr_o == $past(store_addr_o) + 2'd1));

    p_start_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !halted_o);

    p_report_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_wr_o |=> !rpt_wr_o);

    p_irq_after_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(rpt_wr_o));

    p_irq_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> (irq_len_q == 8'(IRQ_CYCLES)));

    p_irq_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> halted_o);

    p_irq_no_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !inc_o);

    p_inc_after_report_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inc_o) |-> $past(rpt_wr_o));

    p_inc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |=> !inc_o);
endmodule

bind bcs_sequencer bcs_sequencer_chk #(.IRQ_CYCLES(IRQ_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halted_o     (halted_o),
    .store_rd_o   (store_rd_o),
    .store_addr_o (store_addr_o),
    .start_o      (start_o),
    .rpt_wr_o     (rpt_wr_o),
    .irq_o        (irq_o),
    .inc_o        (inc_o)
);

// File: tb/sim_bcs_sequencer.sv
module sim_bcs_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_req_i = 1'b0;
    logic        halted_o, store_rd_o, start_o, rpt_wr_o, rpt_retry_o, irq_o, inc_o;
    logic [1:0]  store_addr_o, func_o, bus_sel_o;
    logic [2:0]  msg_o;
    logic [15:0] store_data_i, rx_cmd_o, tx_cmd_o, dptr_o;
    logic        cmd_err_i = 1'b0;
    logic        done_i = 1'b0;
    logic        no_resp_i = 1'b0, enc_err_i = 1'b0, wc_err_i = 1'b0;
    logic        stat_set_i = 1'b0, busy_i = 1'b0;

    logic [15:0] mem [4];
    int checks = 0, errors = 0;
    int cyc = 0, n_start = 0, n_inc = 0, n_rpt = 0, irq_w = 0, n_rd = 0;
    int rpt_cyc = 0, irq_cyc = 0, eng_cnt = 0;
    logic rpt_retry_seen = 1'b0;
    logic [1:0] last_bus = 2'b00, last_func = 2'b00;
    logic [2:0] last_msg = 3'b000;
    logic [1:0] addr_log [8];

    always #10 clk = ~clk;

    always_comb store_data_i = mem[store_addr_o];

    bcs_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i), .halted_o(halted_o),
        .store_rd_o(store_rd_o), .store_addr_o(store_addr_o), .store_data_i(store_data_i),
        .cmd_err_i(cmd_err_i), .start_o(start_o), .func_o(func_o), .msg_o(msg_o),
        .bus_sel_o(bus_sel_o), .rx_cmd_o(rx_cmd_o), .tx_cmd_o(tx_cmd_o), .dptr_o(dptr_o),
        .done_i(done_i), .no_resp_i(no_resp_i), .enc_err_i(enc_err_i), .wc_err_i(wc_err_i),
        .stat_set_i(stat_set_i), .busy_i(busy_i), .rpt_wr_o(rpt_wr_o),
        .rpt_retry_o(rpt_retry_o), .irq_o(irq_o), .inc_o(inc_o)
    );

    // engine model and monitor, both away from the active edge
    always @(negedge clk) begin
        cyc++;
        done_i = 1'b0;
        if (eng_cnt != 0) begin
            eng_cnt--;
            if (eng_cnt == 0) done_i = 1'b1;
        end
        if (start_o) begin
            eng_cnt = 3;
            n_start++;
            last_bus = bus_sel_o; last_func = func_o; last_msg = msg_o;
        end
        if (inc_o) n_inc++;
        if (irq_o) begin
            irq_w++;
            if (irq_cyc == 0) irq_cyc = cyc;
        end
        if (rpt_wr_o) begin
            n_rpt++; rpt_cyc = cyc; rpt_retry_seen = rpt_retry_o;
        end
        if (store_rd_o && n_rd < 8) begin
            addr_log[n_rd] = store_addr_o; n_rd++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_start = 0; n_inc = 0; n_rpt = 0; irq_w = 0; n_rd = 0;
        rpt_cyc = 0; irq_cyc = 0; rpt_retry_seen = 1'b0;
    endtask

    task automatic wait_halted(input logic lvl, input int tmo);
        int n = 0;
        while (halted_o !== lvl && n < tmo) begin
            @(negedge clk); n++;
        end
        chk(halted_o === lvl, "run timeout", int'(halted_o), int'(lvl));
    endtask

    task automatic set_flags(input logic nr, input logic en, input logic wc,
                             input logic st, input logic bz);
        no_resp_i = nr; enc_err_i = en; wc_err_i = wc; stat_set_i = st; busy_i = bz;
    endtask

    // one single-shot instruction
    task automatic run_one(input logic [15:0] w);
        @(negedge clk);
        mem[0] = w;
        halt_req_i = 1'b0;
        repeat (4) @(negedge clk);
        clear_mon();
        halt_req_i = 1'b1;
        wait_halted(1'b0, 20);
        halt_req_i = 1'b0;
        wait_halted(1'b1, 400);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input int cnt, input int rf, input int itf,
                                       input int fn, input int msg);
        return 16'((cnt << 14) | (rf << 11) | (itf << 7) | (fn << 3) | msg);
    endfunction

    initial begin
        mem[0] = 16'h0000; mem[1] = 16'h1A2B; mem[2] = 16'h3C4D; mem[3] = 16'h5E6F;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(halted_o === 1'b1, "R1 halted after reset", int'(halted_o), 1);
        chk({start_o, irq_o, inc_o, rpt_wr_o} === 4'b0, "R1 outputs idle",
            int'({start_o, irq_o, inc_o, rpt_wr_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 first instruction runs as no-op; R2 fetch order and words
        run_one(mk(0, 0, 0, 0, 1));
        chk(n_start == 0, "R3 first instr no start", n_start, 0);
        chk(n_rpt == 1, "R3 first instr report", n_rpt, 1);
        chk(n_inc == 1, "R11 first instr inc", n_inc, 1);
        chk(n_rd == 4, "R2 fetch count", n_rd, 4);
        for (int i = 0; i < 4; i++)
            chk(addr_log[i] == 2'(i), "R2 fetch address order", int'(addr_log[i]), i);
        chk(rx_cmd_o == 16'h1A2B, "R2 rx word", int'(rx_cmd_o), 'h1A2B);
        chk(tx_cmd_o == 16'h3C4D, "R2 tx word", int'(tx_cmd_o), 'h3C4D);
        chk(dptr_o == 16'h5E6F, "R2 pointer word", int'(dptr_o), 'h5E6F);

        // R4 function codes
        for (int fn = 0; fn < 4; fn++) begin
            run_one(mk(0, 0, 0, fn, 5));
            chk(n_start == (fn == 3 ? 0 : 1), "R4 start per function", n_start, fn == 3 ? 0 : 1);
            if (fn != 3) begin
                chk(last_func == 2'(fn), "R4 func_o", int'(last_func), fn);
                chk(last_msg == 3'd5, "R4 msg_o", int'(last_msg), 5);
            end
            chk(n_rpt == 1, "R9 one report", n_rpt, 1);
        end

        // R5 bus select ignores bit 6
        run_one(mk(0, 0, 0, 0, 1) | 16'h0040);
        chk(last_bus == 2'b00, "R5 bit6 only", int'(last_bus), 0);
        run_one(mk(0, 0, 0, 0, 1) | 16'h0060);
        chk(last_bus == 2'b01, "R5 bit5 and bit6", int'(last_bus), 1);

        // R6 R7 retry sweep: failure kinds 0 none 1 no-resp 2 status 3 busy
        for (int cnt = 0; cnt < 4; cnt++)
            for (int rf = 0; rf < 8; rf++)
                for (int fk = 0; fk < 4; fk++) begin
                    automatic bit trig = ((rf & 1) != 0 && fk == 1) ||
                                         ((rf & 2) != 0 && fk == 2) ||
                                         ((rf & 4) != 0 && fk == 3);
                    automatic int exp_st = trig ? cnt + 1 : 1;
                    set_flags(fk == 1, 1'b0, 1'b0, fk == 2, fk == 3);
                    run_one(mk(cnt, rf, 0, 0, 1));
                    chk(n_start == exp_st, "R6 R7 attempts", n_start, exp_st);
                    chk(rpt_retry_seen == (exp_st > 1), "R7 retry flag",
                        int'(rpt_retry_seen), int'(exp_st > 1));
                    chk(n_inc == 1 && irq_w == 0, "R11 inc no irq", n_inc, 1);
                end
        // R6 encoding and word-count errors under bit 11
        set_flags(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_one(mk(2, 1, 0, 0, 1));
        chk(n_start == 3, "R6 enc error retried", n_start, 3);
        set_flags(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_one(mk(3, 1, 0, 0, 1));
        chk(n_start == 4, "R6 wc error retried", n_start, 4);

        // R8 R9 R10 interrupt sweep: 0 none 1 no-resp 2 status 3 enc 4 wc
        for (int itf = 0; itf < 16; itf++)
            for (int fk = 0; fk < 5; fk++) begin
                automatic bit irq_exp = ((itf & 4) != 0) ||
                                        ((itf & 1) != 0 && fk == 1) ||
                                        ((itf & 2) != 0 && fk == 2) ||
                                        ((itf & 8) != 0 && (fk == 3 || fk == 4));
                set_flags(fk == 1, fk == 3, fk == 4, fk == 2, 1'b0);
                run_one(mk(1, 7, itf, 0, 1));
                chk(n_start == (fk == 0 ? 1 : 2), "R7 one retry", n_start, fk == 0 ? 1 : 2);
                chk(irq_w == (irq_exp ? 3 : 0), "R8 R10 irq width", irq_w, irq_exp ? 3 : 0);
                chk(n_inc == (irq_exp ? 0 : 1), "R10 R11 inc", n_inc, irq_exp ? 0 : 1);
                chk(n_rpt == 1, "R9 report count", n_rpt, 1);
                if (irq_exp)
                    chk(rpt_cyc != 0 && rpt_cyc < irq_cyc, "R9 report first", rpt_cyc, irq_cyc - 1);
            end
        set_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R12 command error
        cmd_err_i = 1'b1;
        run_one(mk(0, 0, 0, 0, 1));
        chk(n_start == 0, "R12 no start", n_start, 0);
        chk(n_rpt == 1, "R12 report", n_rpt, 1);
        chk(irq_w == 3, "R12 irq", irq_w, 3);
        cmd_err_i = 1'b0;

        // R10 R1 interrupt halts even with request held high
        @(negedge clk);
        mem[0] = mk(0, 0, 4, 3, 0);
        repeat (4) @(negedge clk);
        clear_mon();
        halt_req_i = 1'b1;
        wait_halted(1'b0, 20);
        wait_halted(1'b1, 400);
        repeat (20) @(negedge clk);
        chk(halted_o === 1'b1, "R1 level high does not restart", int'(halted_o), 1);
        chk(n_rd == 4, "R1 no second fetch", n_rd, 4);
        chk(n_inc == 0, "R10 no inc", n_inc, 0);

        // R11 table mode: request stays high, runs continue
        halt_req_i = 1'b0;
        mem[0] = mk(0, 0, 0, 0, 1);
        repeat (4) @(negedge clk);
        clear_mon();
        halt_req_i = 1'b1;
        begin
            int n = 0;
            while (n_inc < 3 && n < 500) begin @(negedge clk); n++; end
        end
        chk(n_inc >= 3, "R11 table continues", n_inc, 3);
        chk(halted_o === 1'b0, "R11 running in table mode", int'(halted_o), 0);
        halt_req_i = 1'b0;
        wait_halted(1'b1, 400);
        chk(n_start == n_inc, "R11 start per entry", n_start, n_inc);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule